// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the priority core of an eight-input interrupt controller. It keeps the request register (IRR), the in-service register (ISR) and the lowest-priority pin. The mask and the mode flags (auto end-of-interrupt, rotation, cascade nesting, special masking) come in as inputs from a separate command decoder. That decoder, together with the input edge and level logic, feeds per-pin request strobes, acknowledge events and end-of-interrupt (EOI) commands into the block.

Every cycle the block works out two results without a register in the path. The first is the highest-priority pending request that is not masked and not blocked by an in-service level of equal or higher priority. The second is the highest-priority in-service pin that a non-specific EOI would clear. Priority rotates: the scan starts one past the lowest-priority pin and wraps around all pins. The block raises a held interrupt line toward the processor. It updates its registers when the processor acknowledges a pin, and it forms the vector from a base value and the selected pin. When nothing is eligible, it substitutes a spurious pin.

Top module: `irq_prio_engine`

## Requirements
- R1: After reset, IRR and ISR are all zero, the lowest-priority pin is 7 (so pin 0 has the highest priority), and the interrupt line is low.
- R2: Pins are ranked starting from (lowest-priority pin + 1) mod 8 and wrapping through all eight. `req_pin_o` and `eoi_pin_o` report the first qualifying pin in that order.
- R3: A pin qualifies as pending when its IRR bit is 1 and its mask bit is 0. The scan gives no result (`req_valid_o` = 0) if it first reaches a pin whose ISR bit blocks.
- R4: When cascade nesting is enabled (`sfnm_i` = 1), the ISR bit of the cascade pin (pin 2) does not block the pending scan.
- R5: In special mask mode (`smm_i` = 1), ISR does not block the pending scan, and the EOI search skips in-service pins whose mask bit is 1.
- R6: `eoi_cmd_i` = 1 (non-specific) clears the ISR bit at `eoi_pin_o` when `eoi_valid_o` = 1. `eoi_cmd_i` = 2 (specific) clears the ISR bit at `eoi_pin_i`. Codes 0 and 3 do nothing. When `rotate_i` = 1, a clearing EOI also makes the cleared pin the lowest-priority pin.
- R7: On acknowledge (`ack_i` = 1), the pin's IRR bit clears if its source is inactive (`src_active_i` bit = 0). Without auto-EOI, the pin's ISR bit is set. With auto-EOI, ISR is left unchanged and the pin becomes the lowest-priority pin if `rotate_i` = 1.
- R8: `vector_o` = {`base_i`, pin}, where pin is `req_pin_o` when a request is pending and 7 when none is.
- R9: `intr_o` rises on the clock edge after a pending request exists. It stays high until an acknowledge, and it goes low on the edge that takes the acknowledge.
- R10: When a request strobe and an acknowledge hit the same pin in the same cycle, the IRR bit ends up set.
- R11: `prio_set_i` loads `prio_pin_i` as the lowest-priority pin. This load wins over an EOI rotation in the same cycle, and an EOI rotation wins over an auto-EOI acknowledge rotation.
- R12: When an acknowledge and an EOI touch the same ISR bit in the same cycle, the EOI clear is applied after the acknowledge set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_irr_i | input | 8 | Per-pin request strobes that set IRR bits |
| src_active_i | input | 8 | Current level of each request source |
| mask_i | input | 8 | Per-pin mask, 1 = masked |
| auto_eoi_i | input | 1 | Auto end-of-interrupt mode |
| rotate_i | input | 1 | Rotation enable |
| sfnm_i | input | 1 | Cascade nesting: ISR of pin 2 does not block |
| smm_i | input | 1 | Special mask mode |
| ack_i | input | 1 | Acknowledge strobe |
| ack_pin_i | input | 3 | Pin being acknowledged |
| eoi_cmd_i | input | 2 | 0 none, 1 non-specific EOI, 2 specific EOI, 3 none |
| eoi_pin_i | input | 3 | Pin for a specific EOI |
| prio_set_i | input | 1 | Load the lowest-priority pin |
| prio_pin_i | input | 3 | Value for that load |
| base_i | input | 5 | Upper vector bits |
| req_valid_o | output | 1 | A pending request is eligible |
| req_pin_o | output | 3 | Highest eligible pending pin |
| eoi_valid_o | output | 1 | A pin is available for a non-specific EOI |
| eoi_pin_o | output | 3 | Pin a non-specific EOI would clear |
| vector_o | output | 8 | Interrupt vector |
| intr_o | output | 1 | Held interrupt line |
| irr_o | output | 8 | Request register |
| isr_o | output | 8 | In-service register |
| lowprio_o | output | 3 | Current lowest-priority pin |

## Verification
On every cycle, the embedded assertions check the following:
- a reported pending pin really is requested and unmasked;
- a reported EOI pin really is in service, and is unmasked in special mask mode;
- the interrupt line holds until an acknowledge and drops after one;
- request strobes always land in IRR;
- an acknowledge without auto-EOI sets its ISR bit.

Other behaviour can only be shown by the bench's scenarios checked against its reference model:
- the rotating order itself;
- blocking by in-service levels, including the cascade and special-mask exceptions;
- the precedence among lowest-priority updates;
- spurious vector substitution.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [1:0] {
        EOI_NONE    = 2'd0,
        EOI_NONSPEC = 2'd1,
        EOI_SPEC    = 2'd2,
        EOI_RSVD    = 2'd3
    } eoi_kind_e;

endpackage

// File: rtl/irqp_rot_first.sv
module irqp_rot_first #(
    parameter int N_PINS = 8,
    localparam int PIN_W = $clog2(N_PINS)
) (
    input  logic [N_PINS-1:0] vec_i,
    input  logic [PIN_W-1:0]  low_i,
    output logic              hit_o,
    output logic [PIN_W-1:0]  pin_o
);

    logic [PIN_W-1:0] cand;

    // Walk pins from low_i+1 upward, wrapping; the first set bit wins.
    always_comb begin
        hit_o = 1'b0;
        pin_o = low_i;
        cand  = '0;
        for (int k = 0; k < N_PINS; k++) begin
            cand = low_i + PIN_W'(k + 1);
            if (!hit_o && vec_i[cand]) begin
                hit_o = 1'b1;
                pin_o = cand;
            end
        end
    end

endmodule

// File: rtl/irq_prio_engine.sv
module irq_prio_engine
    import irqp_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int CASCADE_PIN = 2,
    parameter int VEC_W       = 8,
    localparam int PIN_W      = $clog2(N_PINS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PINS-1:0]      set_irr_i,
    input  logic [N_PINS-1:0]      src_active_i,
    input  logic [N_PINS-1:0]      mask_i,
    input  logic                   auto_eoi_i,
    input  logic                   rotate_i,
    input  logic                   sfnm_i,
    input  logic                   smm_i,
    input  logic                   ack_i,
    input  logic [PIN_W-1:0]       ack_pin_i,
    input  logic [1:0]             eoi_cmd_i,
    input  logic [PIN_W-1:0]       eoi_pin_i,
    input  logic                   prio_set_i,
    input  logic [PIN_W-1:0]       prio_pin_i,
    input  logic [VEC_W-PIN_W-1:0] base_i,
    output logic                   req_valid_o,
    output logic [PIN_W-1:0]       req_pin_o,
    output logic                   eoi_valid_o,
    output logic [PIN_W-1:0]       eoi_pin_o,
    output logic [VEC_W-1:0]       vector_o,
    output logic                   intr_o,
    output logic [N_PINS-1:0]      irr_o,
    output logic [N_PINS-1:0]      isr_o,
    output logic [PIN_W-1:0]       lowprio_o
);

    localparam logic [N_PINS-1:0] CASC_BIT = N_PINS'(1) << CASCADE_PIN;
    localparam logic [PIN_W-1:0]  SPUR_PIN = PIN_W'(N_PINS - 1);
    localparam logic [PIN_W-1:0]  LOW_RST  = PIN_W'(N_PINS - 1);

    typedef struct packed {
        logic [N_PINS-1:0] irr;
        logic [N_PINS-1:0] isr;
        logic [PIN_W-1:0]  lowprio;
        logic              intr;
    } eng_state_t;

    eng_state_t st_q, st_d;

    // ---------------- priority searches ----------------
    logic [N_PINS-1:0] blk_vec, elig_vec, eoi_cand;
    logic              pend_hit, eoi_hit;
    logic [PIN_W-1:0]  pend_pin, eoi_sel;

    always_comb begin
        blk_vec  = smm_i ? '0 : (st_q.isr & ~(sfnm_i ? CASC_BIT : '0));
        elig_vec = st_q.irr & ~mask_i;
        eoi_cand = smm_i ? (st_q.isr & ~mask_i) : st_q.isr;
    end

    irqp_rot_first #(.N_PINS(N_PINS)) u_pend_scan (
        .vec_i (blk_vec | elig_vec),
        .low_i (st_q.lowprio),
        .hit_o (pend_hit),
        .pin_o (pend_pin)
    );

    irqp_rot_first #(.N_PINS(N_PINS)) u_eoi_scan (
        .vec_i (eoi_cand),
        .low_i (st_q.lowprio),
        .hit_o (eoi_hit),
        .pin_o (eoi_sel)
    );

    // A blocking in-service level reached first ends the search empty.
    assign req_valid_o = pend_hit && !blk_vec[pend_pin];
    assign req_pin_o   = pend_pin;
    assign eoi_valid_o = eoi_hit;
    assign eoi_pin_o   = eoi_sel;
    assign vector_o    = {base_i, (req_valid_o ? req_pin_o : SPUR_PIN)};

    // ---------------- next state ----------------
    eoi_kind_e eoi_kind;
    assign eoi_kind = eoi_kind_e'(eoi_cmd_i);

    always_comb begin
        st_d = st_q;

        if (ack_i) begin
            st_d.intr = 1'b0;
            if (!src_active_i[ack_pin_i]) begin
                st_d.irr[ack_pin_i] = 1'b0;
            end
            if (auto_eoi_i) begin
                if (rotate_i) begin
                    st_d.lowprio = ack_pin_i;
                end
            end else begin
                st_d.isr[ack_pin_i] = 1'b1;
            end
        end else if (req_valid_o) begin
            st_d.intr = 1'b1;
        end

        // New requests override an acknowledge clear on the same pin.
        st_d.irr = st_d.irr | set_irr_i;

        case (eoi_kind)
            EOI_SPEC: begin
                st_d.isr[eoi_pin_i] = 1'b0;
                if (rotate_i) begin
                    st_d.lowprio = eoi_pin_i;
                end
            end
            EOI_NONSPEC: begin
                if (eoi_valid_o) begin
                    st_d.isr[eoi_pin_o] = 1'b0;
                    if (rotate_i) begin
                        st_d.lowprio = eoi_pin_o;
                    end
                end
            end
            default: begin
            end
        endcase

        if (prio_set_i) begin
            st_d.lowprio = prio_pin_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.irr     <= '0;
            st_q.isr     <= '0;
            st_q.lowprio <= LOW_RST;
            st_q.intr    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irr_o     = st_q.irr;
    assign isr_o     = st_q.isr;
    assign lowprio_o = st_q.lowprio;
    assign intr_o    = st_q.intr;

    // ---------------- assertions ----------------
    a_r3_pend_is_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (irr_o[req_pin_o] && !mask_i[req_pin_o]));

    a_r6_eoi_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid_o |-> isr_o[eoi_pin_o]);

    a_r5_smm_skips_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid_o && smm_i) |-> !mask_i[eoi_pin_o]);

    a_r9_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !intr_o);

    a_r9_line_held: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && !ack_i) |=> intr_o);

    a_r10_strobe_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (set_irr_i != '0) |=> ((irr_o & $past(set_irr_i)) == $past(set_irr_i)));

    a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !auto_eoi_i && (eoi_cmd_i == 2'd0)) |=> isr_o[$past(ack_pin_i)]);

endmodule

// File: tb/irq_prio_engine_test.sv
module irq_prio_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] set_irr = '0, src_active = '0, mask = '0;
    logic       auto_eoi = 0, rotate = 0, sfnm = 0, smm = 0;
    logic       ack = 0, prio_set = 0;
    logic [2:0] ack_pin = '0, eoi_pin = '0, prio_pin = '0;
    logic [1:0] eoi_cmd = '0;
    logic [4:0] base = 5'd4;
    logic       req_valid, eoi_valid, intr;
    logic [2:0] req_pin, eoi_pin_o, lowprio;
    logic [7:0] vector, irr, isr;

    always #10 clk = ~clk;

    irq_prio_engine uut (
        .clk(clk), .rst_n(rst_n), .set_irr_i(set_irr), .src_active_i(src_active),
        .mask_i(mask), .auto_eoi_i(auto_eoi), .rotate_i(rotate), .sfnm_i(sfnm),
        .smm_i(smm), .ack_i(ack), .ack_pin_i(ack_pin), .eoi_cmd_i(eoi_cmd),
        .eoi_pin_i(eoi_pin), .prio_set_i(prio_set), .prio_pin_i(prio_pin),
        .base_i(base), .req_valid_o(req_valid), .req_pin_o(req_pin),
        .eoi_valid_o(eoi_valid), .eoi_pin_o(eoi_pin_o), .vector_o(vector),
        .intr_o(intr), .irr_o(irr), .isr_o(isr), .lowprio_o(lowprio)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Reference model state
    bit m_irr[8], m_isr[8], m_intr;
    int m_lp;

    function automatic int ref_pending();
        for (int k = 0; k < 8; k++) begin
            int p = (m_lp + 1 + k) % 8;
            bit blocks = m_isr[p] && !smm && !(sfnm && p == 2);
            if (blocks) return -1;
            if (m_irr[p] && !mask[p]) return p;
        end
        return -1;
    endfunction

    function automatic int ref_eoi();
        for (int k = 0; k < 8; k++) begin
            int p = (m_lp + 1 + k) % 8;
            if (m_isr[p] && !(smm && mask[p])) return p;
        end
        return -1;
    endfunction

    function automatic int pack(input bit v[8]);
        int r = 0;
        for (int i = 0; i < 8; i++) if (v[i]) r += (1 << i);
        return r;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", what, $time, act, exp);
        end
    endtask

    task automatic compare();
        int ep = ref_pending();
        int ee = ref_eoi();
        chk("R3 req_valid", int'(req_valid), int'(ep >= 0));
        if (ep >= 0) chk("R2 req_pin", int'(req_pin), ep);
        chk("R5/R6 eoi_valid", int'(eoi_valid), int'(ee >= 0));
        if (ee >= 0) chk("R2/R6 eoi_pin", int'(eoi_pin_o), ee);
        chk("R8 vector", int'(vector), int'(base) * 8 + ((ep >= 0) ? ep : 7));
        chk("R9 intr", int'(intr), int'(m_intr));
        chk("R7/R10 irr", int'(irr), pack(m_irr));
        chk("R7/R12 isr", int'(isr), pack(m_isr));
        chk("R11 lowprio", int'(lowprio), m_lp);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin m_irr[i] = 0; m_isr[i] = 0; end
        m_lp = 7;
        m_intr = 0;
    endtask

    task automatic model_step();
        int ep = ref_pending();
        int ee = ref_eoi();
        int nlp = m_lp;
        if (!rst_n) begin model_reset(); return; end
        if (ack) begin
            m_intr = 0;
            if (!src_active[ack_pin]) m_irr[ack_pin] = 0;
            if (auto_eoi) begin
                if (rotate) nlp = ack_pin;
            end else m_isr[ack_pin] = 1;
        end else if (ep >= 0) m_intr = 1;
        for (int i = 0; i < 8; i++) if (set_irr[i]) m_irr[i] = 1;
        if (eoi_cmd == 2) begin
            m_isr[eoi_pin] = 0;
            if (rotate) nlp = eoi_pin;
        end else if (eoi_cmd == 1 && ee >= 0) begin
            m_isr[ee] = 0;
            if (rotate) nlp = ee;
        end
        if (prio_set) nlp = prio_pin;
        m_lp = nlp;
    endtask

    // Inputs are set after a falling edge; outputs compared 2 ns before the rising edge.
    task automatic tick();
        #8;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
        set_irr = '0; ack = 0; eoi_cmd = '0; prio_set = 0;
    endtask

    task automatic do_ack(input int p, input bit still_active);
        ack = 1; ack_pin = 3'(p);
        src_active[p] = still_active;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        // R1: reset state observed at the ports
        #8;
        chk("R1 irr", int'(irr), 0);
        chk("R1 isr", int'(isr), 0);
        chk("R1 lowprio", int'(lowprio), 7);
        chk("R1 intr", int'(intr), 0);
        @(negedge clk);

        // R8: nothing pending -> spurious pin 7
        tick();
        // R2/R3/R9: requests on 3 and 5, pin 3 wins, line rises
        set_irr = 8'h28; src_active = 8'h28;
        tick(); tick(); tick();
        // R7: acknowledge 3 with its source gone -> IRR3 clears, ISR3 set
        do_ack(3, 0);
        tick();
        // R3 blocking: request 1 passes, 5 is blocked by ISR3
        set_irr = 8'h02; src_active[1] = 1;
        tick(); tick();
        do_ack(1, 1);
        tick();
        // R6: non-specific EOI clears pin 1 (highest in service)
        eoi_cmd = 2'd1; tick(); tick();
        // R6/R11: specific EOI on 3 with rotation -> lowprio 3
        rotate = 1; eoi_cmd = 2'd2; eoi_pin = 3'd3; tick(); tick();
        // R11: direct load wins over an EOI rotation in the same cycle
        eoi_cmd = 2'd2; eoi_pin = 3'd1; prio_set = 1; prio_pin = 3'd5; tick();
        rotate = 0; prio_set = 1; prio_pin = 3'd7; tick();
        // R4: ISR2 in service blocks pin 6 unless cascade nesting is on
        set_irr = 8'h04; src_active = 8'h00; tick();
        do_ack(2, 0);
        set_irr = 8'h40; src_active[6] = 1; tick(); tick();
        sfnm = 1; tick(); tick();
        sfnm = 0; tick();
        // R5: special mask mode unblocks and hides masked in-service pins
        mask = 8'h04; smm = 1; tick(); tick();
        eoi_cmd = 2'd1; tick();
        smm = 0; mask = 8'h00; tick();
        // R7: auto-EOI with rotation moves lowprio, ISR untouched
        auto_eoi = 1; rotate = 1; tick();
        do_ack(6, 0); tick();
        auto_eoi = 0; rotate = 0;
        // R10: request and acknowledge on the same pin -> IRR stays set
        set_irr = 8'h10; src_active[4] = 0; ack = 1; ack_pin = 3'd4; tick(); tick();
        // R12: acknowledge and specific EOI on the same pin -> ISR clear
        ack = 1; ack_pin = 3'd4; eoi_cmd = 2'd2; eoi_pin = 3'd4; tick(); tick();
        eoi_cmd = 2'd2; eoi_pin = 3'd2; tick(); tick();

        // Mixed traffic against the model
        r = $urandom(32'd11);
        for (int c = 0; c < 3000; c++) begin
            if (c % 97 == 0) begin
                auto_eoi = ($urandom % 4) == 0;
                rotate = ($urandom % 2) == 0;
                sfnm = ($urandom % 3) == 0;
                smm = ($urandom % 4) == 0;
                mask = 8'($urandom) & 8'($urandom);
                base = 5'($urandom);
            end
            src_active = 8'($urandom) & 8'($urandom);
            if ($urandom % 3 == 0) set_irr = 8'(1 << ($urandom % 8));
            if (intr && ($urandom % 2 == 0)) begin
                int p = ref_pending();
                ack = 1; ack_pin = 3'((p >= 0) ? p : 7);
            end
            case ($urandom % 8)
                0: eoi_cmd = 2'd1;
                1: begin eoi_cmd = 2'd2; eoi_pin = 3'($urandom); end
                2: begin prio_set = ($urandom % 4) == 0; prio_pin = 3'($urandom); end
                default: eoi_cmd = 2'($urandom % 4 == 3 ? 3 : 0);
            endcase
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule